// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This unit watches the stream of instruction fetches and data accesses that a core presents and compares each address against four programmable breakpoint registers. Each breakpoint carries two enable bits, one scoped to the current task and one global, and a two-bit access-type field that selects code execution, data writes, or data reads and writes. When an enabled breakpoint matches, the unit pulses an instruction-breakpoint fault for a fetch or a data-breakpoint trap for a data access. It also records the hit in a sticky status vector with one bit per breakpoint.

The status vector follows some deliberately unusual rules. A breakpoint that is disabled but whose address and type match still records a hit, but only while at least one other breakpoint is enabled. It never raises a fault or trap, even when the fetch also carries a page fault. An interrupt-instruction event wipes all recorded hits. A system-management interrupt that arrives in the same cycle as a data access pre-empts that access's breakpoint, so neither a trap nor a status bit results from it. Software loads the address, control and status registers through a simple write port.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: Write selector values 0 to 3 load breakpoint address registers 0 to 3, selector 4 loads the control word, and selector 5 loads the status vector. A write takes effect from the next cycle, and an access in the same cycle uses the old contents.
- R2: In the control word, breakpoint n has its task enable at bit 2n, its global enable at bit 2n+1, and its type field at bits 16+2n and 17+2n. The breakpoint is enabled when either enable bit is 1.
- R3: The access kind is encoded as 00 idle, 01 fetch, 10 data read and 11 data write. Type 00 matches a fetch at an equal address. When the matching breakpoint is enabled, the fault output is high for exactly the cycle after the fetch, and the trap output stays low.
- R4: Type 01 matches data writes only, and type 11 matches data reads and data writes. An enabled match pulses the trap output in the cycle after the access.
- R5: Type 10 never matches any access kind. It sets no status bit and raises no pulse.
- R6: A matching breakpoint that is disabled sets its status bit only if some other breakpoint is enabled in that cycle. It never produces a fault or trap, whether or not the page-fault flag is set.
- R7: An enabled match sets its status bit, visible one cycle after the access. Status bits stay set until software overwrites them. A status write replaces the vector, and hits from the same cycle are ORed into the written value.
- R8: An interrupt-instruction event clears every status bit in the next cycle. It overrides a status write or any hit in the same cycle.
- R9: A system-management interrupt in the same cycle as a data access suppresses that access's trap and its status updates. Fetches in that cycle are unaffected.
- R10: A synchronous active-low reset clears all addresses, enables, types and status bits, and holds both pulse outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_kind_i | input | 2 | Access kind: 00 idle, 01 fetch, 10 read, 11 write |
| acc_addr_i | input | AW | Address of the presented access |
| pf_i | input | 1 | The presented fetch also reports a page fault |
| intn_i | input | 1 | Interrupt-instruction event |
| smi_i | input | 1 | System-management interrupt event |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | SELW | Register selector: 0-3 address, 4 control, 5 status |
| wr_data_i | input | AW | Write data |
| status_o | output | NUM_BP | Sticky hit bits, one per breakpoint |
| ifault_o | output | 1 | Instruction-breakpoint fault pulse |
| dtrap_o | output | 1 | Data-breakpoint trap pulse |

## Verification
A wrong enable, type or address register shows up at the ports in the cycle after the next matching access, as a missing or extra fault or trap pulse and a wrong status bit. Corrupted status state is visible directly on the status output one cycle after the event that caused it. Because status is sticky, that error persists until the next interrupt-instruction event or status write. Confusion between the disabled-hit rule and the enabled-hit rule appears only when the other breakpoints' enables change. The stimulus therefore mixes enable patterns with a small address pool, so that disabled and enabled matches happen often.

// File: rtl/dbg_bkpt_pkg.sv
// Shared encodings for the breakpoint match unit.
// Assumes: access kind and type field are two bits wide.
package dbg_bkpt_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_FETCH = 2'b01,
        ACC_READ  = 2'b10,
        ACC_WRITE = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        BT_EXEC = 2'b00,
        BT_WR   = 2'b01,
        BT_RSVD = 2'b10,
        BT_RDWR = 2'b11
    } bp_type_e;

    // Control word field positions
    localparam int CTRL_TYPE_BASE = 16;

    // Register selector codes beyond the address registers
    localparam int SEL_CTRL_OFS = 0;
    localparam int SEL_STAT_OFS = 1;

endpackage

// File: rtl/dbg_bkpt_regs.sv
// Breakpoint configuration registers: one address per breakpoint plus the
// enable pairs and type fields unpacked from the control word.
// Assumes: NUM_BP <= 8 so the type fields fit above bit 16 of the word.
module dbg_bkpt_regs
    import dbg_bkpt_pkg::*;
#(
    parameter int NUM_BP = 4,
    parameter int AW     = 32,
    parameter int SELW   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SELW-1:0]               wr_sel,
    input  logic [AW-1:0]                 wr_data,
    output logic [NUM_BP-1:0][AW-1:0]     bp_addr,
    output logic [NUM_BP-1:0]             bp_en,
    output logic [NUM_BP-1:0][1:0]        bp_type
);

    localparam logic [SELW-1:0] SEL_CTRL = SELW'(NUM_BP + SEL_CTRL_OFS);

    logic [NUM_BP-1:0] en_task_q;
    logic [NUM_BP-1:0] en_glob_q;
    logic              ctrl_wr;

    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

    genvar n;
    generate
        for (n = 0; n < NUM_BP; n++) begin : g_bp
            // Address register n loads on its own selector code
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bp_addr[n] <= '0;
                else if (wr_en && (wr_sel == SELW'(n)))
                    bp_addr[n] <= wr_data;
            end

            // Enable pair and type field n load from the control word
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_task_q[n] <= 1'b0;
                    en_glob_q[n] <= 1'b0;
                    bp_type[n]   <= BT_EXEC;
                end else if (ctrl_wr) begin
                    en_task_q[n] <= wr_data[2*n];
                    en_glob_q[n] <= wr_data[2*n+1];
                    bp_type[n]   <= wr_data[CTRL_TYPE_BASE+2*n +: 2];
                end
            end

            // A breakpoint is live if either scope enables it
            assign bp_en[n] = en_task_q[n] | en_glob_q[n];

            // R1: an address write is visible on the next cycle
            p_addr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_sel == SELW'(n)) |=> (bp_addr[n] == $past(wr_data)));
        end
    endgenerate

    // R2: a control write with both enable bits of breakpoint 0 clear leaves it off
    p_ctrl_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data[1:0] == 2'b00) |=> !bp_en[0]);

endmodule

// File: rtl/dbg_bkpt_cmp.sv
// Single breakpoint comparator: decides whether the presented access is of
// the kind the type field selects and hits the stored address exactly.
// Assumes: byte-granular match, no length masking.
module dbg_bkpt_cmp
    import dbg_bkpt_pkg::*;
#(
    parameter int AW = 32
) (
    input  acc_kind_e      acc_kind,
    input  logic [AW-1:0]  acc_addr,
    input  logic [AW-1:0]  bp_addr,
    input  logic [1:0]     bp_type,
    output logic           hit
);

    logic kind_ok;

    // Type field selects which access kinds are eligible
    always_comb begin
        unique case (bp_type_e'(bp_type))
            BT_EXEC: kind_ok = (acc_kind == ACC_FETCH);
            BT_WR:   kind_ok = (acc_kind == ACC_WRITE);
            BT_RDWR: kind_ok = (acc_kind == ACC_READ) || (acc_kind == ACC_WRITE);
            default: kind_ok = 1'b0;
        endcase
    end

    // Eligible kind plus identical address is a hit
    assign hit = kind_ok && (acc_addr == bp_addr);

endmodule

// File: rtl/dbg_bkpt_status.sv
// Hit qualification, sticky status vector and registered fault/trap pulses.
// Assumes: hit and enable vectors are combinational from the current cycle.
module dbg_bkpt_status
    import dbg_bkpt_pkg::*;
#(
    parameter int NUM_BP = 4,
    parameter int AW     = 32,
    parameter int SELW   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  acc_kind_e            acc_kind,
    input  logic [NUM_BP-1:0]    hit,
    input  logic [NUM_BP-1:0]    bp_en,
    input  logic                 intn_i,
    input  logic                 smi_i,
    input  logic                 wr_en,
    input  logic [SELW-1:0]      wr_sel,
    input  logic [AW-1:0]        wr_data,
    output logic [NUM_BP-1:0]    status_o,
    output logic                 ifault_o,
    output logic                 dtrap_o
);

    localparam logic [SELW-1:0]   SEL_STAT = SELW'(NUM_BP + SEL_STAT_OFS);
    localparam logic [NUM_BP-1:0] ONE      = NUM_BP'(1);

    logic              is_fetch;
    logic              is_data;
    logic              data_drop;
    logic              stat_wr;
    logic [NUM_BP-1:0] live_hit;
    logic [NUM_BP-1:0] set_vec;
    logic [NUM_BP-1:0] stat_next;

    assign is_fetch  = (acc_kind == ACC_FETCH);
    assign is_data   = (acc_kind == ACC_READ) || (acc_kind == ACC_WRITE);
    assign data_drop = smi_i && is_data;
    assign stat_wr   = wr_en && (wr_sel == SEL_STAT);
    assign live_hit  = hit & bp_en;

    genvar n;
    generate
        for (n = 0; n < NUM_BP; n++) begin : g_set
            // Hit counts if own enable or any other breakpoint is live
            assign set_vec[n] = hit[n] && !data_drop &&
                                (bp_en[n] || (|(bp_en & ~(ONE << n))));
        end
    endgenerate

    // Next status: interrupt clear wins, then software write, then accumulate
    always_comb begin
        if (intn_i)
            stat_next = '0;
        else if (stat_wr)
            stat_next = wr_data[NUM_BP-1:0] | set_vec;
        else
            stat_next = status_o | set_vec;
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_o <= '0;
        else
            status_o <= stat_next;
    end

    // Fault and trap pulses one cycle after the access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ifault_o <= 1'b0;
            dtrap_o  <= 1'b0;
        end else begin
            ifault_o <= is_fetch && (|live_hit);
            dtrap_o  <= is_data && !smi_i && (|live_hit);
        end
    end

    // R8: interrupt instruction empties the status vector
    p_intn_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        intn_i |=> (status_o == '0));

    // R9: no trap follows a system-management interrupt
    p_smi_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smi_i |=> !dtrap_o);

    // R7: without a clear or a status write, bits only accumulate
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!intn_i && !stat_wr) |=> ((status_o & $past(status_o)) == $past(status_o)));

endmodule

// File: rtl/dbg_bkpt_unit.sv
// Top of the breakpoint match unit: configuration registers, one comparator
// per breakpoint, and the status/pulse stage.
// Assumes: one access per cycle; address translation done upstream.
module dbg_bkpt_unit
    import dbg_bkpt_pkg::*;
#(
    parameter  int NUM_BP = 4,
    parameter  int AW     = 32,
    localparam int SELW   = $clog2(NUM_BP + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           acc_kind_i,
    input  logic [AW-1:0]        acc_addr_i,
    input  logic                 pf_i,
    input  logic                 intn_i,
    input  logic                 smi_i,
    input  logic                 wr_en_i,
    input  logic [SELW-1:0]      wr_sel_i,
    input  logic [AW-1:0]        wr_data_i,
    output logic [NUM_BP-1:0]    status_o,
    output logic                 ifault_o,
    output logic                 dtrap_o
);

    acc_kind_e                   kind;
    logic [NUM_BP-1:0][AW-1:0]   bp_addr;
    logic [NUM_BP-1:0]           bp_en;
    logic [NUM_BP-1:0][1:0]      bp_type;
    logic [NUM_BP-1:0]           hit;

    assign kind = acc_kind_e'(acc_kind_i);

    dbg_bkpt_regs #(.NUM_BP(NUM_BP), .AW(AW), .SELW(SELW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_sel  (wr_sel_i),
        .wr_data (wr_data_i),
        .bp_addr (bp_addr),
        .bp_en   (bp_en),
        .bp_type (bp_type)
    );

    genvar n;
    generate
        for (n = 0; n < NUM_BP; n++) begin : g_cmp
            dbg_bkpt_cmp #(.AW(AW)) u_cmp (
                .acc_kind (kind),
                .acc_addr (acc_addr_i),
                .bp_addr  (bp_addr[n]),
                .bp_type  (bp_type[n]),
                .hit      (hit[n])
            );
        end
    endgenerate

    dbg_bkpt_status #(.NUM_BP(NUM_BP), .AW(AW), .SELW(SELW)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_kind (kind),
        .hit      (hit),
        .bp_en    (bp_en),
        .intn_i   (intn_i),
        .smi_i    (smi_i),
        .wr_en    (wr_en_i),
        .wr_sel   (wr_sel_i),
        .wr_data  (wr_data_i),
        .status_o (status_o),
        .ifault_o (ifault_o),
        .dtrap_o  (dtrap_o)
    );

    // R6: a page-faulting fetch that hits no live breakpoint raises no fault
    p_dis_nofault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_FETCH && pf_i && !(|(hit & bp_en))) |=> !ifault_o);

    // R3: a fault and a trap never pulse together
    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ifault_o, dtrap_o}));

    // R10: pulse outputs idle in the cycle after reset
    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> (!ifault_o && !dtrap_o && status_o == '0));

endmodule

// File: tb/dbg_bkpt_unit_test.sv
`timescale 1ns/1ps
module dbg_bkpt_unit_test;

    localparam int N  = 4;
    localparam int AW = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic [1:0]    acc_kind;
    logic [AW-1:0] acc_addr;
    logic          pf, intn, smi, wr_en;
    logic [2:0]    wr_sel;
    logic [AW-1:0] wr_data;
    logic [N-1:0]  status;
    logic          ifault, dtrap;

    dbg_bkpt_unit #(.NUM_BP(N), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .acc_kind_i(acc_kind), .acc_addr_i(acc_addr),
        .pf_i(pf), .intn_i(intn), .smi_i(smi), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .status_o(status), .ifault_o(ifault), .dtrap_o(dtrap)
    );

    int total = 0;
    int bad   = 0;

    // Reference model state
    logic [AW-1:0] m_addr [N];
    logic [1:0]    m_type [N];
    logic [N-1:0]  m_l, m_g, m_st;
    logic          m_if, m_dt;
    string         tag  = "R10";
    string         ptag = "R10";

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", ptag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input logic [3:0] l, input logic [3:0] g,
                                            input logic [7:0] t);
        logic [31:0] d = '0;
        for (int n = 0; n < N; n++) begin
            d[2*n]          = l[n];
            d[2*n+1]        = g[n];
            d[16+2*n +: 2]  = t[2*n +: 2];
        end
        return d;
    endfunction

    function automatic logic kind_ok(input logic [1:0] t, input logic [1:0] k);
        return (t == 2'b00 && k == 2'b01) || (t == 2'b01 && k == 2'b11) ||
               (t == 2'b11 && (k == 2'b10 || k == 2'b11));
    endfunction

    // One cycle: check last cycle's effect, drive new inputs, advance the model
    task automatic step(input logic r, input logic [1:0] k, input logic [31:0] a,
                        input logic p, input logic i, input logic s,
                        input logic w, input logic [2:0] sl, input logic [31:0] d);
        logic [N-1:0] en, hit, setv;
        logic isd;
        @(negedge clk);
        chk("status", 32'(status), 32'(m_st));
        chk("ifault", 32'(ifault), 32'(m_if));
        chk("dtrap",  32'(dtrap),  32'(m_dt));
        ptag = tag;
        rst_n = r; acc_kind = k; acc_addr = a; pf = p; intn = i; smi = s;
        wr_en = w; wr_sel = sl; wr_data = d;
        if (!r) begin
            for (int n = 0; n < N; n++) begin m_addr[n] = '0; m_type[n] = '0; end
            m_l = '0; m_g = '0; m_st = '0; m_if = 1'b0; m_dt = 1'b0;
        end else begin
            en  = m_l | m_g;
            isd = (k == 2'b10) || (k == 2'b11);
            for (int n = 0; n < N; n++)
                hit[n] = kind_ok(m_type[n], k) && (a == m_addr[n]);
            for (int n = 0; n < N; n++)
                setv[n] = hit[n] && !(s && isd) &&
                          (en[n] || ((en & ~(N'(1) << n)) != '0));
            m_if = (k == 2'b01) && ((hit & en) != '0);
            m_dt = isd && !s && ((hit & en) != '0);
            if (i)                     m_st = '0;
            else if (w && sl == 3'd5)  m_st = d[N-1:0] | setv;
            else                       m_st = m_st | setv;
            if (w && sl < 3'd4) m_addr[sl[1:0]] = d;
            if (w && sl == 3'd4)
                for (int n = 0; n < N; n++) begin
                    m_l[n] = d[2*n]; m_g[n] = d[2*n+1]; m_type[n] = d[16+2*n +: 2];
                end
        end
    endtask

    task automatic acc(input logic [1:0] k, input logic [31:0] a, input logic p,
                       input logic i, input logic s);
        step(1'b1, k, a, p, i, s, 1'b0, 3'd0, 32'h0);
    endtask

    task automatic wr(input logic [2:0] sl, input logic [31:0] d);
        step(1'b1, 2'b00, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, sl, d);
    endtask

    task automatic idle();
        acc(2'b00, 32'h0, 1'b0, 1'b0, 1'b0);
    endtask

    function automatic logic [31:0] pool_addr();
        return 32'h100 + 32'($urandom_range(0, 5)) * 32'h100;
    endfunction

    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d0c5));
        rst_n = 1'b0; acc_kind = 2'b00; acc_addr = '0; pf = 1'b0; intn = 1'b0;
        smi = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        for (int n = 0; n < N; n++) begin m_addr[n] = '0; m_type[n] = '0; end
        m_l = '0; m_g = '0; m_st = '0; m_if = 1'b0; m_dt = 1'b0;

        // R10: reset state, with a fetch presented while in reset
        tag = "R10";
        step(1'b0, 2'b01, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 32'hffff_ffff);
        step(1'b0, 2'b00, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0);
        idle();

        // R1 / R2: load breakpoint 0 as execution, task enable only
        tag = "R1";
        wr(3'd0, 32'h100);
        acc(2'b01, 32'h100, 1'b0, 1'b0, 1'b0);   // same-cycle-old: ctrl still zero
        tag = "R2";
        wr(3'd4, mk_ctrl(4'b0001, 4'b0000, 8'h00));
        // R3: fetch hit pulses fault once
        tag = "R3";
        acc(2'b01, 32'h100, 1'b0, 1'b0, 1'b0);
        acc(2'b10, 32'h100, 1'b0, 1'b0, 1'b0);
        idle();

        // R4: breakpoint 1 write-only, global enable
        tag = "R4";
        wr(3'd1, 32'h200);
        wr(3'd4, mk_ctrl(4'b0001, 4'b0010, {2'b00, 2'b00, 2'b01, 2'b00}));
        acc(2'b10, 32'h200, 1'b0, 1'b0, 1'b0);
        acc(2'b11, 32'h200, 1'b0, 1'b0, 1'b0);
        wr(3'd4, mk_ctrl(4'b0001, 4'b0010, {2'b00, 2'b00, 2'b11, 2'b00}));
        acc(2'b10, 32'h200, 1'b0, 1'b0, 1'b0);
        idle();

        // R5: reserved type on breakpoint 2 stays silent
        tag = "R5";
        wr(3'd5, 32'h0);
        wr(3'd2, 32'h300);
        wr(3'd4, mk_ctrl(4'b0100, 4'b0000, {2'b00, 2'b10, 2'b00, 2'b00}));
        acc(2'b01, 32'h300, 1'b0, 1'b0, 1'b0);
        acc(2'b10, 32'h300, 1'b0, 1'b0, 1'b0);
        acc(2'b11, 32'h300, 1'b0, 1'b0, 1'b0);
        idle();

        // R6: disabled breakpoint 3 with another enabled, fetch with page fault
        tag = "R6";
        wr(3'd3, 32'h400);
        wr(3'd4, mk_ctrl(4'b0001, 4'b0000, 8'h00));
        acc(2'b01, 32'h400, 1'b1, 1'b0, 1'b0);
        idle();
        wr(3'd5, 32'h0);
        wr(3'd4, mk_ctrl(4'b0000, 4'b0000, 8'h00));
        acc(2'b01, 32'h400, 1'b1, 1'b0, 1'b0);   // nothing enabled: no status bit
        idle();

        // R7: sticky bits, write replaces, same-cycle hit ORed in
        tag = "R7";
        wr(3'd4, mk_ctrl(4'b0001, 4'b0000, 8'h00));
        acc(2'b01, 32'h100, 1'b0, 1'b0, 1'b0);
        idle(); idle();
        wr(3'd5, 32'h4);
        step(1'b1, 2'b01, 32'h100, 1'b0, 1'b0, 1'b0, 1'b1, 3'd5, 32'h2);
        idle();

        // R8: interrupt clear beats same-cycle hit and status write
        tag = "R8";
        step(1'b1, 2'b01, 32'h100, 1'b0, 1'b1, 1'b0, 1'b1, 3'd5, 32'hf);
        idle();

        // R9: system-management interrupt drops the data trap, not a fetch
        tag = "R9";
        wr(3'd4, mk_ctrl(4'b0001, 4'b0010, {2'b00, 2'b00, 2'b11, 2'b00}));
        acc(2'b11, 32'h200, 1'b0, 1'b0, 1'b1);
        acc(2'b01, 32'h100, 1'b0, 1'b0, 1'b1);
        idle();

        // Random mix against the model
        tag = "R7";
        for (int c = 0; c < 4000; c++) begin
            int sel_r = $urandom_range(0, 99);
            if (sel_r < 15) begin
                int s = $urandom_range(0, 5);
                if (s < 4)       wr(3'(s), pool_addr());
                else if (s == 4) wr(3'd4, mk_ctrl(4'($urandom), 4'($urandom), 8'($urandom)));
                else             wr(3'd5, 32'($urandom));
            end else begin
                acc(2'($urandom), pool_addr(), 1'($urandom),
                    ($urandom_range(0, 99) < 5), ($urandom_range(0, 99) < 10));
            end
        end
        idle();
        idle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule